// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block sits on the host side of a single-data-line serial flash. It takes one erase request and performs it. A request carries an erase kind (one sector or whole dies), a 32-bit sector address, a die count and a poll limit, and is launched by a start strobe. For every erase it does the following in order: it sends a write-enable frame, then sends the erase frame with a 4-byte address, then reads the status register repeatedly until the write-in-progress bit reads clear. Each frame uses its own chip-select window. The flash starts its self-timed erase on the rising edge of chip select.

On parts made of several dies, the block repeats the enable, erase and poll sequence once per die. It addresses die n at n × 2^25 bytes. It reports activity on `busy`. It ends with a one-cycle `done` pulse or, when the flash stays busy for more polls than allowed, with a one-cycle `timeout` pulse. In both cases it returns to idle with chip select high.

Top module: `flash_erase_seq`

## Requirements
- R1: Out of reset and while idle, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `timeout` are 0.
- R2: Every erase is preceded by a write-enable frame in its own chip-select window: opcode 06h, 8 clocks, MSB first.
- R3: A sector erase (`die_mode`=0) sends opcode D8h followed by `addr[31:0]` unchanged, MSB first, for 40 clocks in one frame. `die_count` has no effect in this mode, so exactly one erase is done.
- R4: A die erase (`die_mode`=1) sends opcode C4h followed by the 32-bit address die_index × 2^25, for 40 clocks. Dies 0 to `die_count`−1 are erased in ascending order. A `die_count` of 0 acts as 1.
- R5: The serial clock idles low. The data line changes only while the clock is low, and the flash samples it on the rising edge. The clock is low whenever chip select is high. Chip select rises only after the last clock of a frame and stays high for at least one cycle between frames.
- R6: Status is read with opcode 05h followed by 8 read clocks (16 clocks in all). Bit 0 of the byte read, MSB first, is write-in-progress. Polling repeats while that bit is 1.
- R7: For each die, the order is write enable, erase, then polls. The next die starts only after a poll has read write-in-progress as 0.
- R8: If `poll_limit` consecutive polls for one erase read write-in-progress as 1, `timeout` pulses for one cycle. The block then goes idle with chip select high and issues no further frames. A `poll_limit` of 0 acts as 1.
- R9: A poll that reads write-in-progress as 0 ends that erase normally even when it is the last poll the limit allows.
- R10: `busy` is 1 from the cycle after an accepted start until the end. `done` pulses for one cycle when all erases finish, and `busy` is 0 in that cycle. `done` and `timeout` are never 1 together.
- R11: A `start` pulse while `busy` is 1 is ignored, and the request in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, taken only when idle |
| die_mode | input | 1 | 1 = whole-die erase, 0 = sector erase |
| addr | input | 32 | Any byte address inside the target sector |
| die_count | input | DIE_W | Number of dies to erase in die mode |
| poll_limit | input | POLL_W | Maximum busy status reads per erase |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when the poll limit is reached |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Completion and timeout are both decided on the same status read. That read can be the last one the limit allows and still show write-in-progress clear. The bench makes its flash responder report busy for exactly `poll_limit`−1 reads and then clear, and expects `done` with no `timeout`. It then repeats the run with the responder busy for `poll_limit` reads and expects `timeout`, no `done`, exactly `poll_limit` poll frames, and no frame after that.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_WREN    = 3'd1,
        S_WREN_W  = 3'd2,
        S_ERASE   = 3'd3,
        S_ERASE_W = 3'd4,
        S_POLL    = 3'd5,
        S_POLL_W  = 3'd6
    } seq_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_SECT  = 8'hD8;
    localparam logic [7:0] OP_DIE   = 8'hC4;
    localparam int         DIE_SHIFT = 25;
    localparam int         FRAME_W   = 40;
    localparam int         BITCNT_W  = 6;

endpackage

// File: rtl/fes_shifter.sv
module fes_shifter #(
    parameter int HALF_CYC = 2,
    parameter int FRAME_W  = 40,
    parameter int CNT_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [7:0]         rx_byte,
    output logic               fin
);
    localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

    typedef struct packed {
        logic               active;
        logic               sck;
        logic               fin;
        logic [DIV_W-1:0]   div;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic [7:0]         rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.fin = 1'b0;
        if (!sh_q.active) begin
            if (go) begin
                sh_d.active = 1'b1;
                sh_d.shreg  = tx;
                sh_d.cnt    = nbits;
                sh_d.div    = '0;
                sh_d.sck    = 1'b0;
            end
        end else if (sh_q.div == DIV_LAST) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                // rising half: the device has held its data since the last fall
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[6:0], miso};
            end else begin
                sh_d.sck   = 1'b0;
                sh_d.shreg = sh_q.shreg << 1;
                sh_d.cnt   = sh_q.cnt - 1'b1;
                if (sh_q.cnt == CNT_W'(1)) begin
                    sh_d.active = 1'b0;
                    sh_d.fin    = 1'b1;
                end
            end
        end else begin
            sh_d.div = sh_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck     = sh_q.sck;
    assign mosi    = sh_q.shreg[FRAME_W-1];
    assign rx_byte = sh_q.rx;
    assign fin     = sh_q.fin;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int DIE_W    = 3,
    parameter int POLL_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              die_mode,
    input  logic [31:0]       addr,
    input  logic [DIE_W-1:0]  die_count,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam logic [DIE_W:0] ONE_D = (DIE_W+1)'(1);

    typedef struct packed {
        seq_state_e        state;
        logic              die_mode;
        logic [31:0]       addr;
        logic [DIE_W-1:0]  count_tgt;
        logic [POLL_W-1:0] limit;
        logic [DIE_W-1:0]  die_idx;
        logic [POLL_W-1:0] poll_cnt;
        logic              cs_n;
        logic              done;
        logic              timeout;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               sh_go;
    logic [FRAME_W-1:0] sh_tx;
    logic [BITCNT_W-1:0] sh_nbits;
    logic [7:0]         sh_rx;
    logic               sh_fin;
    logic [31:0]        die_addr;

    assign die_addr = 32'(seq_q.die_idx) << DIE_SHIFT;

    always_comb begin
        seq_d         = seq_q;
        seq_d.done    = 1'b0;
        seq_d.timeout = 1'b0;
        sh_go         = 1'b0;
        sh_tx         = '0;
        sh_nbits      = '0;
        unique case (seq_q.state)
            S_IDLE: begin
                if (start) begin
                    seq_d.die_mode  = die_mode;
                    seq_d.addr      = addr;
                    seq_d.count_tgt = (!die_mode || die_count == '0) ? DIE_W'(1) : die_count;
                    seq_d.limit     = (poll_limit == '0) ? POLL_W'(1) : poll_limit;
                    seq_d.die_idx   = '0;
                    seq_d.state     = S_WREN;
                end
            end
            S_WREN: begin
                sh_go          = 1'b1;
                sh_tx          = {OP_WREN, 32'h0};
                sh_nbits       = BITCNT_W'(8);
                seq_d.cs_n     = 1'b0;
                seq_d.poll_cnt = '0;
                seq_d.state    = S_WREN_W;
            end
            S_WREN_W: begin
                if (sh_fin) begin
                    seq_d.cs_n  = 1'b1;
                    seq_d.state = S_ERASE;
                end
            end
            S_ERASE: begin
                sh_go       = 1'b1;
                sh_tx       = seq_q.die_mode ? {OP_DIE, die_addr} : {OP_SECT, seq_q.addr};
                sh_nbits    = BITCNT_W'(FRAME_W);
                seq_d.cs_n  = 1'b0;
                seq_d.state = S_ERASE_W;
            end
            S_ERASE_W: begin
                if (sh_fin) begin
                    seq_d.cs_n  = 1'b1;
                    seq_d.state = S_POLL;
                end
            end
            S_POLL: begin
                sh_go       = 1'b1;
                sh_tx       = {OP_RDSR, 32'h0};
                sh_nbits    = BITCNT_W'(16);
                seq_d.cs_n  = 1'b0;
                seq_d.state = S_POLL_W;
            end
            S_POLL_W: begin
                if (sh_fin) begin
                    seq_d.cs_n = 1'b1;
                    if (!sh_rx[0]) begin
                        // a clear reading wins even on the last permitted poll
                        if (({1'b0, seq_q.die_idx} + ONE_D) == {1'b0, seq_q.count_tgt}) begin
                            seq_d.done  = 1'b1;
                            seq_d.state = S_IDLE;
                        end else begin
                            seq_d.die_idx = seq_q.die_idx + 1'b1;
                            seq_d.state   = S_WREN;
                        end
                    end else if ((seq_q.poll_cnt + 1'b1) >= seq_q.limit) begin
                        seq_d.timeout = 1'b1;
                        seq_d.state   = S_IDLE;
                    end else begin
                        seq_d.poll_cnt = seq_q.poll_cnt + 1'b1;
                        seq_d.state    = S_POLL;
                    end
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    fes_shifter #(
        .HALF_CYC (HALF_CYC),
        .FRAME_W  (FRAME_W),
        .CNT_W    (BITCNT_W)
    ) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx      (sh_tx),
        .nbits   (sh_nbits),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx),
        .fin     (sh_fin)
    );

    assign busy     = (seq_q.state != S_IDLE);
    assign done     = seq_q.done;
    assign timeout  = seq_q.timeout;
    assign spi_cs_n = seq_q.cs_n;

endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    a_r5_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r5_data_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    a_r10_outcome_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy);

    a_r10_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r8_timeout_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> spi_cs_n);
endmodule

bind flash_erase_seq fes_checker i_fes_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;
    localparam int DIE_W  = 3;
    localparam int POLL_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic die_mode = 1'b0;
    logic [31:0] addr = '0;
    logic [DIE_W-1:0] die_count = '0;
    logic [POLL_W-1:0] poll_limit = '0;
    logic busy, done, timeout, spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    flash_erase_seq #(.HALF_CYC(2), .DIE_W(DIE_W), .POLL_W(POLL_W)) i_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .die_mode(die_mode), .addr(addr),
        .die_count(die_count), .poll_limit(poll_limit), .busy(busy), .done(done),
        .timeout(timeout), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // flash responder
    logic [39:0] rsp_sh = '0;
    int          rsp_bits = 0;
    logic [7:0]  rsp_op = '0;
    logic [7:0]  rsp_stat = '0;
    logic        wel = 1'b0;
    logic        wip = 1'b0;
    int          busy_cfg = 0;
    int          busy_left = 0;
    int          no_wel_err = 0;
    int          nlog = 0;
    logic [7:0]  log_op [64];
    int          log_bits [64];
    logic [31:0] log_addr [64];

    always @(negedge spi_cs_n) begin
        rsp_bits = 0;
        rsp_sh   = '0;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        rsp_sh   = {rsp_sh[38:0], spi_mosi};
        rsp_bits = rsp_bits + 1;
        if (rsp_bits == 8) begin
            rsp_op   = rsp_sh[7:0];
            rsp_stat = {6'b0, wel, wip};
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n && rsp_bits >= 8 && rsp_bits < 16 && rsp_op == 8'h05)
        spi_miso = rsp_stat[15 - rsp_bits];

    always @(posedge spi_cs_n) if (rsp_bits > 0) begin
        if (nlog < 64) begin
            log_op[nlog]   = (rsp_bits >= 8) ? rsp_op : 8'h00;
            log_bits[nlog] = rsp_bits;
            log_addr[nlog] = rsp_sh[31:0];
        end
        nlog = nlog + 1;
        if (rsp_op == 8'h06 && rsp_bits == 8) wel = 1'b1;
        if ((rsp_op == 8'hD8 || rsp_op == 8'hC4) && rsp_bits == 40) begin
            if (!wel) no_wel_err = no_wel_err + 1;
            wel       = 1'b0;
            busy_left = busy_cfg;
            wip       = (busy_cfg > 0);
        end
        if (rsp_op == 8'h05 && rsp_bits == 16 && wip) begin
            busy_left = busy_left - 1;
            if (busy_left == 0) wip = 1'b0;
        end
        rsp_bits = 0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launch one request and wait for its outcome; optionally poke a second start mid-run
    task automatic run_req(input logic mode, input logic [31:0] a, input logic [DIE_W-1:0] cnt,
                           input logic [POLL_W-1:0] lim, input int k, input bit poke,
                           output bit got_done, output bit got_to);
        nlog = 0;
        no_wel_err = 0;
        busy_cfg = k;
        got_done = 1'b0;
        got_to = 1'b0;
        @(negedge clk);
        die_mode = mode; addr = a; die_count = cnt; poll_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", {63'b0, busy}, 64'd1);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (poke && i == 20) begin
                die_mode = ~mode; addr = 32'hFFFF_FFFF; die_count = '1; poll_limit = 16'd1;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done || timeout) begin
                got_done = done;
                got_to = timeout;
                check("R10 idle at outcome", {63'b0, busy}, 64'd0);
                check("R10 not both outcomes", {63'b0, done & timeout}, 64'd0);
                break;
            end
        end
        @(negedge clk);
        check("R10 outcome is one pulse", {62'b0, done, timeout}, 64'd0);
        check("R1 chip select high after end", {63'b0, spi_cs_n}, 64'd1);
        check("R2 no erase without enable", 64'(no_wel_err), 64'd0);
    endtask

    // verify the frame log for ndies dies with k busy polls each
    task automatic check_frames(input string req, input logic mode, input logic [31:0] a,
                                input int ndies, input int k);
        int per = k + 3;
        check({req, " frame count"}, 64'(nlog), 64'(ndies * per));
        for (int d = 0; d < ndies; d++) begin
            int b = d * per;
            if (b + per <= 64) begin
                check("R2 enable opcode", {56'b0, log_op[b]}, 64'h06);
                check("R2 enable length", 64'(log_bits[b]), 64'd8);
                check({req, " erase opcode"}, {56'b0, log_op[b+1]}, mode ? 64'hC4 : 64'hD8);
                check({req, " erase length"}, 64'(log_bits[b+1]), 64'd40);
                check({req, " erase address"}, {32'b0, log_addr[b+1]},
                      mode ? 64'(d) << 25 : {32'b0, a});
                for (int p = 0; p < k + 1; p++) begin
                    check("R6 poll opcode", {56'b0, log_op[b+2+p]}, 64'h05);
                    check("R6 poll length", 64'(log_bits[b+2+p]), 64'd16);
                end
            end
        end
    endtask

    task automatic t_reset;
        check("R1 cs_n idle", {63'b0, spi_cs_n}, 64'd1);
        check("R1 sck idle", {63'b0, spi_sck}, 64'd0);
        check("R1 flags idle", {61'b0, busy, done, timeout}, 64'd0);
    endtask

    task automatic t_sector;
        bit dn, to;
        run_req(1'b0, 32'h0123_4567, 3'd5, 16'd10, 3, 1'b0, dn, to);
        check("R3 sector done", {62'b0, dn, to}, 64'b10);
        check_frames("R3", 1'b0, 32'h0123_4567, 1, 3);
    endtask

    task automatic t_dies4;
        bit dn, to;
        run_req(1'b1, 32'hDEAD_BEEF, 3'd4, 16'd8, 1, 1'b0, dn, to);
        check("R7 four dies done", {62'b0, dn, to}, 64'b10);
        check_frames("R4", 1'b1, 32'h0, 4, 1);
    endtask

    task automatic t_dies2_fast;
        bit dn, to;
        run_req(1'b1, 32'h0, 3'd2, 16'd4, 0, 1'b0, dn, to);
        check("R7 two dies done", {62'b0, dn, to}, 64'b10);
        check_frames("R4", 1'b1, 32'h0, 2, 0);
    endtask

    task automatic t_zero_count;
        bit dn, to;
        run_req(1'b1, 32'h0, 3'd0, 16'd4, 2, 1'b0, dn, to);
        check("R4 zero count one die", {62'b0, dn, to}, 64'b10);
        check_frames("R4", 1'b1, 32'h0, 1, 2);
    endtask

    task automatic t_limit_edge;
        bit dn, to;
        run_req(1'b0, 32'h0080_0000, 3'd1, 16'd3, 2, 1'b0, dn, to);
        check("R9 clear on last poll", {62'b0, dn, to}, 64'b10);
        check_frames("R9", 1'b0, 32'h0080_0000, 1, 2);
    endtask

    task automatic t_timeout;
        bit dn, to;
        int seen;
        run_req(1'b0, 32'h0000_1000, 3'd1, 16'd3, 3, 1'b0, dn, to);
        check("R8 timeout raised", {62'b0, dn, to}, 64'b01);
        check("R8 poll frames", 64'(nlog), 64'd5);
        seen = nlog;
        repeat (100) @(negedge clk);
        check("R8 no further frames", 64'(nlog), 64'(seen));
        check("R8 cs high after timeout", {63'b0, spi_cs_n}, 64'd1);
        busy_cfg = 0; wip = 1'b0;
    endtask

    task automatic t_zero_limit;
        bit dn, to;
        run_req(1'b0, 32'h0, 3'd1, 16'd0, 5, 1'b0, dn, to);
        check("R8 zero limit acts as one", {62'b0, dn, to}, 64'b01);
        check("R8 zero limit one poll", 64'(nlog), 64'd3);
        busy_cfg = 0; wip = 1'b0;
    endtask

    task automatic t_ignore_start;
        bit dn, to;
        run_req(1'b0, 32'h0ABC_0000, 3'd1, 16'd6, 2, 1'b1, dn, to);
        check("R11 start ignored", {62'b0, dn, to}, 64'b10);
        check_frames("R11", 1'b0, 32'h0ABC_0000, 1, 2);
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_sector();
        t_dies4();
        t_dies2_fast();
        t_zero_count();
        t_limit_edge();
        t_timeout();
        t_zero_limit();
        t_ignore_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule